// File: doc/BRIEF.md
# Instruction Decoder and Legality Checker

This combinational block takes one 32-bit instruction word and breaks it into operands in a single pass. The top six bits select one of 39 defined operations. The opcode also fixes whether the word uses the register layout or the immediate layout. The decoder extracts the register specifiers, the shift count and the 16-bit immediate. It widens the immediate to 32 bits, with sign or zero fill chosen by the opcode. It also reports an operation class, a base-address register and a software-interrupt code.

The decoder enforces a strict encoding discipline. A register field that an operation does not use must hold the placeholder specifier 0x17. A field the operation does use must not hold it. Every malformed word raises a single illegal flag. This covers a reserved opcode, a stray shift count, non-zero padding, or a misplaced register. An execution stage downstream can then trap on the flag without decoding the word again.

Top module: `instr_decoder`

## Requirements
- R1: In the register layout (format 0), src_a = bits [25:21], src_b = [20:16], dst = [15:11] and shamt = [10:6]. In the immediate layout (format 1), src_a = [25:21] and dst = [20:16], while src_b reads as 0x17 and shamt reads as 0.
- R2: fmt_imm_o is 1 for opcodes 0x03 to 0x13, 0x22, 0x25 and 0x26, and 0 for every other opcode, reserved ones included.
- R3: imm_ext_o is bits [15:0] zero-extended for opcodes 0x0B and 0x0C. It is sign-extended for every other immediate-layout opcode, and it is 0 in the register layout.
- R4: op_class_o encodings are:
  - 0: opcode 0x00
  - 1 (copy): 0x01 and 0x02
  - 2 (load): 0x03 to 0x07
  - 3 (store): 0x08 to 0x0A
  - 4 (literal): 0x0B and 0x0C
  - 5 (jump): 0x0D
  - 6 (conditional branch): 0x0E to 0x13
  - 7 (compare): 0x14
  - 8 (add/subtract): 0x15, 0x16, 0x19, 0x1A, 0x25 and 0x26
  - 9 (bitwise): 0x1B to 0x21
  - 10 (shift): 0x17 and 0x18
  - 11 (system): 0x22 to 0x24
  - 15: reserved opcodes
- R5: Opcodes 0x27 to 0x3F are illegal whatever their other bits hold.
- R6: In the register layout, any non-zero bit in [5:0] makes the word illegal.
- R7: A non-zero shamt is illegal on every register-layout opcode other than 0x17 and 0x18.
- R8: For opcodes 0x17 and 0x18, the count source depends on src_b.
  - src_b = 0x17 raises count_from_lit_o.
  - Any other src_b raises count_from_reg_o, and a non-zero shamt is then illegal.
  - Both flags are 0 for other opcodes.
- R9: Operand usage is checked field by field. A required field must not be 0x17, and an unused field must be 0x17; any violation is illegal. The rules are, as (src_a, src_b, dst), with req = required and unused = must be 0x17:
  - 0x00, 0x23 and 0x24: unused, unused, unused.
  - 0x01, 0x02 and 0x1D: req, unused, req.
  - 0x14: req, req, unused.
  - 0x15 and 0x16: req, unused, req.
  - 0x17 and 0x18: req, either, req.
  - Other register-layout opcodes: req, req, req.
  - Loads, stores, 0x25 and 0x26: src_a and dst both required.
  - 0x0B to 0x13: src_a unused and dst required.
  - 0x22: src_a and dst both unused.
- R10: For opcodes 0x15, 0x16, 0x17 and 0x18, dst must equal src_a, otherwise the word is illegal.
- R11: base_o is src_a for loads. It is dst for stores, jumps and conditional branches, and 0x17 otherwise.
- R12: irq_code_o is bits [7:0] for opcode 0x22 and 0 for all other opcodes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word |
| fmt_imm_o | output | 1 | 1 = immediate layout, 0 = register layout |
| op_class_o | output | 4 | Operation class code |
| illegal_o | output | 1 | Malformed or reserved encoding |
| src_a_o | output | 5 | First source specifier |
| src_b_o | output | 5 | Second source specifier (0x17 in immediate layout) |
| dst_o | output | 5 | Destination specifier |
| base_o | output | 5 | Base-address register for memory and control transfer |
| shamt_o | output | 5 | Literal shift count field |
| count_from_reg_o | output | 1 | Shift count taken from the register in src_b |
| count_from_lit_o | output | 1 | Shift count taken from shamt |
| imm_ext_o | output | 32 | Extended immediate |
| irq_code_o | output | 8 | Software interrupt code |

## Verification
The sweep covers every one of the 64 opcodes. Each source and destination field is crossed between a real register and the placeholder. The destination is sometimes equal to src_a and sometimes not, which separates the rule that a register must be repeated from the plain rule that a field is required. The shift count is zero or non-zero and the padding is clean or dirty, so a stray-count failure can be told apart from a padding failure. A destination value of 0x1F drives bit 15 of the immediate high, which shows sign fill versus zero fill. Directed words then isolate single violations, one each: a reserved opcode, a count on a register-count shift, and an increment whose destination differs from its source.

// File: rtl/instdec_pkg.sv
package instdec_pkg;

  typedef enum logic {
    FMT_REG = 1'b0,
    FMT_IMM = 1'b1
  } fmt_e;

  typedef enum logic [3:0] {
    CLS_NONE    = 4'd0,
    CLS_COPY    = 4'd1,
    CLS_LOAD    = 4'd2,
    CLS_STORE   = 4'd3,
    CLS_LITERAL = 4'd4,
    CLS_JUMP    = 4'd5,
    CLS_BRANCH  = 4'd6,
    CLS_COMPARE = 4'd7,
    CLS_ADDSUB  = 4'd8,
    CLS_BITWISE = 4'd9,
    CLS_SHIFT   = 4'd10,
    CLS_SYSTEM  = 4'd11,
    CLS_INVALID = 4'd15
  } opclass_e;

  // How one register field is constrained by an opcode
  typedef enum logic [1:0] {
    USE_ANY   = 2'd0,
    USE_REQ   = 2'd1,
    USE_EMPTY = 2'd2
  } use_e;

  typedef struct packed {
    logic     valid;
    fmt_e     fmt;
    opclass_e cls;
    use_e     use_a;
    use_e     use_b;
    use_e     use_d;
    logic     d_is_a;
    logic     zext;
    logic     is_shift;
    logic     base_in_a;
    logic     base_in_d;
    logic     is_irq;
  } rule_t;

endpackage

// File: rtl/instdec_rules.sv
module instdec_rules
  import instdec_pkg::*;
#(
  parameter int OP_W = 6
) (
  input  logic [OP_W-1:0] op_i,
  output rule_t           rule_o
);

  rule_t r;

  always_comb begin
    r.valid     = 1'b1;
    r.fmt       = FMT_REG;
    r.cls       = CLS_INVALID;
    r.use_a     = USE_ANY;
    r.use_b     = USE_ANY;
    r.use_d     = USE_ANY;
    r.d_is_a    = 1'b0;
    r.zext      = 1'b0;
    r.is_shift  = 1'b0;
    r.base_in_a = 1'b0;
    r.base_in_d = 1'b0;
    r.is_irq    = 1'b0;
    case (op_i)
      6'h00: begin
        r.cls = CLS_NONE;
        r.use_a = USE_EMPTY; r.use_b = USE_EMPTY; r.use_d = USE_EMPTY;
      end
      6'h01, 6'h02: begin
        r.cls = CLS_COPY;
        r.use_a = USE_REQ; r.use_b = USE_EMPTY; r.use_d = USE_REQ;
      end
      6'h03, 6'h04, 6'h05, 6'h06, 6'h07: begin
        r.fmt = FMT_IMM; r.cls = CLS_LOAD;
        r.use_a = USE_REQ; r.use_d = USE_REQ; r.base_in_a = 1'b1;
      end
      6'h08, 6'h09, 6'h0A: begin
        r.fmt = FMT_IMM; r.cls = CLS_STORE;
        r.use_a = USE_REQ; r.use_d = USE_REQ; r.base_in_d = 1'b1;
      end
      6'h0B, 6'h0C: begin
        r.fmt = FMT_IMM; r.cls = CLS_LITERAL; r.zext = 1'b1;
        r.use_a = USE_EMPTY; r.use_d = USE_REQ;
      end
      6'h0D: begin
        r.fmt = FMT_IMM; r.cls = CLS_JUMP;
        r.use_a = USE_EMPTY; r.use_d = USE_REQ; r.base_in_d = 1'b1;
      end
      6'h0E, 6'h0F, 6'h10, 6'h11, 6'h12, 6'h13: begin
        r.fmt = FMT_IMM; r.cls = CLS_BRANCH;
        r.use_a = USE_EMPTY; r.use_d = USE_REQ; r.base_in_d = 1'b1;
      end
      6'h14: begin
        r.cls = CLS_COMPARE;
        r.use_a = USE_REQ; r.use_b = USE_REQ; r.use_d = USE_EMPTY;
      end
      6'h15, 6'h16: begin
        r.cls = CLS_ADDSUB; r.d_is_a = 1'b1;
        r.use_a = USE_REQ; r.use_b = USE_EMPTY; r.use_d = USE_REQ;
      end
      6'h17, 6'h18: begin
        r.cls = CLS_SHIFT; r.d_is_a = 1'b1; r.is_shift = 1'b1;
        r.use_a = USE_REQ; r.use_b = USE_ANY; r.use_d = USE_REQ;
      end
      6'h19, 6'h1A: begin
        r.cls = CLS_ADDSUB;
        r.use_a = USE_REQ; r.use_b = USE_REQ; r.use_d = USE_REQ;
      end
      6'h1D: begin
        r.cls = CLS_BITWISE;
        r.use_a = USE_REQ; r.use_b = USE_EMPTY; r.use_d = USE_REQ;
      end
      6'h1B, 6'h1C, 6'h1E, 6'h1F, 6'h20, 6'h21: begin
        r.cls = CLS_BITWISE;
        r.use_a = USE_REQ; r.use_b = USE_REQ; r.use_d = USE_REQ;
      end
      6'h22: begin
        r.fmt = FMT_IMM; r.cls = CLS_SYSTEM; r.is_irq = 1'b1;
        r.use_a = USE_EMPTY; r.use_d = USE_EMPTY;
      end
      6'h23, 6'h24: begin
        r.cls = CLS_SYSTEM;
        r.use_a = USE_EMPTY; r.use_b = USE_EMPTY; r.use_d = USE_EMPTY;
      end
      6'h25, 6'h26: begin
        r.fmt = FMT_IMM; r.cls = CLS_ADDSUB;
        r.use_a = USE_REQ; r.use_d = USE_REQ;
      end
      default: r.valid = 1'b0;
    endcase
  end

  assign rule_o = r;

endmodule

// File: rtl/instdec_fields.sv
module instdec_fields #(
  parameter int            WORD_W = 32,
  parameter int            OP_W   = 6,
  parameter int            REG_W  = 5,
  parameter int            SH_W   = 5,
  parameter int            PAD_W  = 6,
  parameter int            IMM_W  = 16,
  parameter int            IRQ_W  = 8,
  parameter logic [REG_W-1:0] PH  = 5'h17
) (
  input  logic [WORD_W-OP_W-1:0] body_i,
  input  logic                   fmt_imm_i,
  input  logic                   zext_i,
  input  logic                   irq_i,
  output logic [REG_W-1:0]       a_o,
  output logic [REG_W-1:0]       b_o,
  output logic [REG_W-1:0]       d_o,
  output logic [SH_W-1:0]        shamt_o,
  output logic                   pad_nz_o,
  output logic [WORD_W-1:0]      imm_ext_o,
  output logic [IRQ_W-1:0]       irq_code_o
);

  localparam int BODY_W = WORD_W - OP_W;
  localparam int A_LSB  = BODY_W - REG_W;
  localparam int B_LSB  = A_LSB - REG_W;
  localparam int D_LSB  = B_LSB - REG_W;
  localparam int SH_LSB = D_LSB - SH_W;
  localparam int FILL_W = WORD_W - IMM_W;

  logic [IMM_W-1:0] imm;
  logic             fill_bit;

  assign imm      = body_i[IMM_W-1:0];
  assign fill_bit = imm[IMM_W-1] & ~zext_i;

  always_comb begin
    a_o = body_i[A_LSB +: REG_W];
    if (fmt_imm_i) begin
      b_o       = PH;
      d_o       = body_i[B_LSB +: REG_W];
      shamt_o   = '0;
      pad_nz_o  = 1'b0;
      imm_ext_o = {{FILL_W{fill_bit}}, imm};
    end else begin
      b_o       = body_i[B_LSB +: REG_W];
      d_o       = body_i[D_LSB +: REG_W];
      shamt_o   = body_i[SH_LSB +: SH_W];
      pad_nz_o  = |body_i[PAD_W-1:0];
      imm_ext_o = '0;
    end
    irq_code_o = irq_i ? imm[IRQ_W-1:0] : '0;
  end

endmodule

// File: rtl/instdec_check.sv
module instdec_check
  import instdec_pkg::*;
#(
  parameter int               REG_W = 5,
  parameter int               SH_W  = 5,
  parameter logic [REG_W-1:0] PH    = 5'h17
) (
  input  logic             valid_i,
  input  use_e             use_a_i,
  input  use_e             use_b_i,
  input  use_e             use_d_i,
  input  logic             d_is_a_i,
  input  logic             is_shift_i,
  input  logic             base_in_a_i,
  input  logic             base_in_d_i,
  input  logic [REG_W-1:0] a_i,
  input  logic [REG_W-1:0] b_i,
  input  logic [REG_W-1:0] d_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  logic             pad_nz_i,
  output logic             illegal_o,
  output logic             cnt_reg_o,
  output logic             cnt_lit_o,
  output logic [REG_W-1:0] base_o
);

  localparam int NFIELD = 3;

  logic [REG_W-1:0] fval [NFIELD];
  use_e             fuse [NFIELD];
  logic [NFIELD-1:0] fbad;

  assign fval[0] = a_i;  assign fuse[0] = use_a_i;
  assign fval[1] = b_i;  assign fuse[1] = use_b_i;
  assign fval[2] = d_i;  assign fuse[2] = use_d_i;

  // One placeholder rule per register field
  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    assign fbad[i] = ((fuse[i] == USE_REQ)   && (fval[i] == PH)) ||
                     ((fuse[i] == USE_EMPTY) && (fval[i] != PH));
  end

  logic shamt_nz, mirror_bad;

  assign shamt_nz   = |shamt_i;
  assign mirror_bad = d_is_a_i && (d_i != a_i);
  assign cnt_lit_o  = is_shift_i && (b_i == PH);
  assign cnt_reg_o  = is_shift_i && (b_i != PH);

  assign illegal_o = !valid_i || (|fbad) || mirror_bad || pad_nz_i ||
                     (!is_shift_i && shamt_nz) || (cnt_reg_o && shamt_nz);

  assign base_o = base_in_a_i ? a_i : (base_in_d_i ? d_i : PH);

  always_comb begin
    p_count_src_r8: assert ($onehot0({cnt_reg_o, cnt_lit_o}))
      else $error("count source flags both set");
    if (!illegal_o && cnt_reg_o)
      p_reg_count_clean_r8: assert (!shamt_nz)
        else $error("register count accepted with literal count");
  end

endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import instdec_pkg::*;
#(
  parameter int               WORD_W = 32,
  parameter int               OP_W   = 6,
  parameter int               REG_W  = 5,
  parameter int               SH_W   = 5,
  parameter int               PAD_W  = 6,
  parameter int               IMM_W  = 16,
  parameter int               IRQ_W  = 8,
  parameter logic [REG_W-1:0] PH     = 5'h17,
  parameter int               N_DEF  = 39
) (
  input  logic [WORD_W-1:0] instr_i,
  output logic              fmt_imm_o,
  output logic [3:0]        op_class_o,
  output logic              illegal_o,
  output logic [REG_W-1:0]  src_a_o,
  output logic [REG_W-1:0]  src_b_o,
  output logic [REG_W-1:0]  dst_o,
  output logic [REG_W-1:0]  base_o,
  output logic [SH_W-1:0]   shamt_o,
  output logic              count_from_reg_o,
  output logic              count_from_lit_o,
  output logic [WORD_W-1:0] imm_ext_o,
  output logic [IRQ_W-1:0]  irq_code_o
);

  localparam logic [OP_W-1:0] FIRST_RES = OP_W'(N_DEF);
  localparam int              FILL_W    = WORD_W - IMM_W;

  logic [OP_W-1:0] opcode;
  rule_t           rule;
  logic            pad_nz;

  assign opcode = instr_i[WORD_W-1 -: OP_W];

  instdec_rules #(.OP_W(OP_W)) u_rules (
    .op_i   (opcode),
    .rule_o (rule)
  );

  instdec_fields #(
    .WORD_W(WORD_W), .OP_W(OP_W), .REG_W(REG_W), .SH_W(SH_W),
    .PAD_W(PAD_W), .IMM_W(IMM_W), .IRQ_W(IRQ_W), .PH(PH)
  ) u_fields (
    .body_i     (instr_i[WORD_W-OP_W-1:0]),
    .fmt_imm_i  (rule.fmt == FMT_IMM),
    .zext_i     (rule.zext),
    .irq_i      (rule.is_irq),
    .a_o        (src_a_o),
    .b_o        (src_b_o),
    .d_o        (dst_o),
    .shamt_o    (shamt_o),
    .pad_nz_o   (pad_nz),
    .imm_ext_o  (imm_ext_o),
    .irq_code_o (irq_code_o)
  );

  instdec_check #(.REG_W(REG_W), .SH_W(SH_W), .PH(PH)) u_check (
    .valid_i     (rule.valid),
    .use_a_i     (rule.use_a),
    .use_b_i     (rule.use_b),
    .use_d_i     (rule.use_d),
    .d_is_a_i    (rule.d_is_a),
    .is_shift_i  (rule.is_shift),
    .base_in_a_i (rule.base_in_a),
    .base_in_d_i (rule.base_in_d),
    .a_i         (src_a_o),
    .b_i         (src_b_o),
    .d_i         (dst_o),
    .shamt_i     (shamt_o),
    .pad_nz_i    (pad_nz),
    .illegal_o   (illegal_o),
    .cnt_reg_o   (count_from_reg_o),
    .cnt_lit_o   (count_from_lit_o),
    .base_o      (base_o)
  );

  assign fmt_imm_o  = (rule.fmt == FMT_IMM);
  assign op_class_o = rule.cls;

  always_comb begin
    if (opcode >= FIRST_RES)
      p_reserved_illegal_r5: assert (illegal_o && op_class_o == 4'd15)
        else $error("reserved opcode accepted");
    if (!fmt_imm_o)
      p_reg_layout_no_imm_r3: assert (imm_ext_o == '0)
        else $error("immediate leaked in register layout");
    if (fmt_imm_o && rule.zext)
      p_zero_fill_r3: assert (imm_ext_o[WORD_W-1 -: FILL_W] == '0)
        else $error("literal immediate not zero filled");
    if (!rule.is_irq)
      p_irq_quiet_r12: assert (irq_code_o == '0)
        else $error("interrupt code outside interrupt opcode");
    if (fmt_imm_o)
      p_imm_no_shamt_r1: assert (shamt_o == '0 && src_b_o == PH)
        else $error("register-layout fields in immediate layout");
  end

endmodule

// File: tb/instr_decoder_bench.sv
module instr_decoder_bench;

  localparam int         CLK_PERIOD = 10;
  localparam logic [4:0] PH = 5'h17;

  logic clk, rst_n;
  logic [31:0] instr;
  logic        fmt_imm, illegal, c_reg, c_lit;
  logic [3:0]  cls;
  logic [4:0]  sa, sb, dd, base, sh;
  logic [31:0] imm;
  logic [7:0]  irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  instr_decoder u_instr_decoder (
    .instr_i(instr), .fmt_imm_o(fmt_imm), .op_class_o(cls), .illegal_o(illegal),
    .src_a_o(sa), .src_b_o(sb), .dst_o(dd), .base_o(base), .shamt_o(sh),
    .count_from_reg_o(c_reg), .count_from_lit_o(c_lit), .imm_ext_o(imm),
    .irq_code_o(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s instr=%h got=%h exp=%h", tag, instr, got, exp);
    end
  endtask

  function automatic bit is_imm_op(input logic [5:0] op);
    return (op >= 6'h03 && op <= 6'h13) || op == 6'h22 || op == 6'h25 || op == 6'h26;
  endfunction

  function automatic logic [3:0] exp_class(input logic [5:0] op);
    if (op >= 6'h27) return 4'd15;
    if (op == 6'h00) return 4'd0;
    if (op <= 6'h02) return 4'd1;
    if (op <= 6'h07) return 4'd2;
    if (op <= 6'h0A) return 4'd3;
    if (op <= 6'h0C) return 4'd4;
    if (op == 6'h0D) return 4'd5;
    if (op <= 6'h13) return 4'd6;
    if (op == 6'h14) return 4'd7;
    if (op == 6'h17 || op == 6'h18) return 4'd10;
    if (op <= 6'h1A || op >= 6'h25) return 4'd8;
    if (op <= 6'h21) return 4'd9;
    return 4'd11;
  endfunction

  function automatic bit exp_illegal(input logic [31:0] w);
    logic [5:0] op = w[31:26];
    logic [4:0] a = w[25:21], b = w[20:16], d = w[15:11], s = w[10:6];
    bit bad = 0;
    if (op >= 6'h27) return 1'b1;
    if (is_imm_op(op)) begin
      // immediate layout: destination lives in [20:16]
      if (op == 6'h22)                      bad = (a != PH) || (b != PH);
      else if (op >= 6'h0B && op <= 6'h13)  bad = (a != PH) || (b == PH);
      else                                  bad = (a == PH) || (b == PH);
      return bad;
    end
    if (w[5:0] != 0) bad = 1;
    case (op)
      6'h00, 6'h23, 6'h24: bad |= (a != PH) || (b != PH) || (d != PH) || (s != 0);
      6'h01, 6'h02, 6'h1D: bad |= (a == PH) || (b != PH) || (d == PH) || (s != 0);
      6'h14:               bad |= (a == PH) || (b == PH) || (d != PH) || (s != 0);
      6'h15, 6'h16:        bad |= (a == PH) || (b != PH) || (d != a) || (s != 0);
      6'h17, 6'h18:        bad |= (a == PH) || (d != a) || ((b != PH) && (s != 0));
      default:             bad |= (a == PH) || (b == PH) || (d == PH) || (s != 0);
    endcase
    return bad;
  endfunction

  task automatic apply(input logic [31:0] w);
    @(posedge clk);
    instr = w;
    @(negedge clk);
  endtask

  task automatic check_all(input logic [31:0] w);
    logic [5:0] op = w[31:26];
    bit i_op = is_imm_op(op);
    bit zx = (op == 6'h0B || op == 6'h0C);
    bit shf = (op == 6'h17 || op == 6'h18);
    logic [4:0] eb = i_op ? PH : w[20:16];
    logic [4:0] ed = i_op ? w[20:16] : w[15:11];
    logic [31:0] ei;
    logic [4:0] ebase;
    if (!i_op)   ei = 32'h0;
    else if (zx) ei = {16'h0, w[15:0]};
    else         ei = {{16{w[15]}}, w[15:0]};
    if (op >= 6'h03 && op <= 6'h07)      ebase = w[25:21];
    else if (op >= 6'h08 && op <= 6'h13 && op != 6'h0B && op != 6'h0C) ebase = ed;
    else                                 ebase = PH;
    chk("R2 format", {31'h0, fmt_imm}, {31'h0, i_op});
    chk("R4 class", {28'h0, cls}, {28'h0, exp_class(op)});
    chk("R5 R6 R7 R9 R10 illegal", {31'h0, illegal}, {31'h0, exp_illegal(w)});
    chk("R1 fields", {17'h0, sa, sb, dd, sh}, {17'h0, w[25:21], eb, ed, i_op ? 5'h0 : w[10:6]});
    chk("R3 immediate", imm, ei);
    chk("R8 count source", {30'h0, c_reg, c_lit}, {30'h0, shf && eb != PH, shf && eb == PH});
    chk("R11 base", {27'h0, base}, {27'h0, ebase});
    chk("R12 irq code", {24'h0, irq}, {24'h0, (op == 6'h22) ? w[7:0] : 8'h0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [4:0] av [2] = '{5'h03, PH};
    logic [4:0] bv [2] = '{PH, 5'h07};
    logic [4:0] dv [3] = '{5'h03, PH, 5'h1F};
    logic [4:0] sv [2] = '{5'h00, 5'h05};
    logic [5:0] lv [2] = '{6'h00, 6'h20};
    instr = 32'h0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset state: canonical no-operation word is legal with placeholders
    apply({6'h00, PH, PH, PH, 5'h0, 6'h0});
    chk("R9 reset nop legal", {31'h0, illegal}, 32'h0);
    chk("R4 reset nop class", {28'h0, cls}, 32'h0);

    // Directed single violations
    apply({6'h27, 5'h1, 5'h2, 5'h3, 5'h0, 6'h0});
    chk("R5 reserved 0x27", {31'h0, illegal}, 32'h1);
    apply({6'h19, 5'h1, 5'h2, 5'h3, 5'h0, 6'h01});
    chk("R6 padding bit", {31'h0, illegal}, 32'h1);
    apply({6'h19, 5'h1, 5'h2, 5'h3, 5'h4, 6'h00});
    chk("R7 count on add", {31'h0, illegal}, 32'h1);
    apply({6'h17, 5'h1, 5'h2, 5'h1, 5'h4, 6'h00});
    chk("R8 register count with literal", {31'h0, illegal}, 32'h1);
    apply({6'h17, 5'h1, PH, 5'h1, 5'h4, 6'h00});
    chk("R8 literal count legal", {31'h0, illegal}, 32'h0);
    chk("R8 literal flag", {31'h0, c_lit}, 32'h1);
    apply({6'h15, 5'h1, PH, 5'h2, 5'h0, 6'h00});
    chk("R10 increment mirror", {31'h0, illegal}, 32'h1);
    apply({6'h01, PH, PH, 5'h2, 5'h0, 6'h00});
    chk("R9 copy from placeholder", {31'h0, illegal}, 32'h1);
    apply({6'h0B, PH, 5'h4, 16'hBEEF});
    chk("R3 literal zero fill", imm, 32'h0000BEEF);
    apply({6'h25, 5'h2, 5'h4, 16'hBEEF});
    chk("R3 add sign fill", imm, 32'hFFFFBEEF);

    // Sweep: all opcodes crossed with field patterns
    for (int op = 0; op < 64; op++)
      for (int ai = 0; ai < 2; ai++)
        for (int bi = 0; bi < 2; bi++)
          for (int di = 0; di < 3; di++)
            for (int si = 0; si < 2; si++)
              for (int li = 0; li < 2; li++) begin
                logic [31:0] w;
                w = {op[5:0], (di == 0) ? av[ai] : av[ai] ^ 5'h00, bv[bi], dv[di], sv[si], lv[li]};
                apply(w);
                check_all(w);
              end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule